// File: doc/BRIEF.md
# Host Pin Event Flag Register

This block is one 8-bit status and control register for a peripheral that answers a host bus. Two external pins from the host side, the bus reset line and the power-down request line, each pass through a synchronizer and a falling-edge detector. Each detected falling edge sets a sticky interrupt flag. The local CPU clears a flag with a two-step handshake. First it reads the register while the flag shows 1. Then it writes 0 to that flag position.

The register also shows the live, synchronized level of the gate-A20 pin. It holds one read/write output-control bit. That bit is ANDed with an enable supplied from a neighbouring register to drive a host-facing control line. The two flags are ORed into one registered, active-high error interrupt request.

A falling edge on the bus reset pin also clears the power-down flag. A software-reset level from elsewhere in the interface clears it too. When a set and a clear reach a flag in the same cycle, the set wins.

Top module: `hpe_flag_reg`

## Requirements
- R1: After synchronous reset, register bits 6..0 read 0, `irq_o` is 0 and `host_ctl_o` is 0.
- R2: Bit 7 of `rdata_o` returns the level of `a20_pin_i` after a `SYNC_STAGES`-flop synchronizer. Bits 4..1 always read 0, and writes to them have no effect.
- R3: Bit 6 (bus-reset flag) becomes 1 on the (`SYNC_STAGES`+1)-th rising clock edge after `bus_rst_n_i` goes from 1 to 0. A pin that only stays at 0 never sets it.
- R4: Bit 5 (power-down flag) becomes 1 on the (`SYNC_STAGES`+1)-th rising clock edge after `pwr_dn_n_i` goes from 1 to 0.
- R5: A flag is cleared by a write whose bit at that flag's position is 0, but only if a read (`sel_i` and `rd_i`) returned that flag as 1 since the last write. Any write ends that armed state. A write of 0 without such a read leaves the flag at 1. Writing 1 never sets a flag.
- R6: The power-down flag is also cleared by a detected falling edge on `bus_rst_n_i`, and in every cycle in which `sw_rst_i` is 1.
- R7: If a set event and a clear event reach the same flag in the same cycle, the flag is 1 afterwards. In particular, falling edges on both pins in the same cycle leave both flags at 1.
- R8: `irq_o` is 1 exactly one cycle after a cycle in which either flag is 1.
- R9: Bit 0 is a read/write control bit that resets to 0. `host_ctl_o` is 1 only when bit 0 is 1 and `ctl_en_i` is 1.
- R10: A flag cleared by the handshake stays 0 while its pin remains at 0. Only a new falling edge sets it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_rst_n_i | input | 1 | Asynchronous host bus reset pin, active low |
| pwr_dn_n_i | input | 1 | Asynchronous power-down request pin, active low |
| a20_pin_i | input | 1 | Asynchronous gate-A20 pin, monitored only |
| sw_rst_i | input | 1 | Software-reset level from the interface control logic |
| ctl_en_i | input | 1 | Enable for the host control output, held elsewhere |
| sel_i | input | 1 | Register select |
| rd_i | input | 1 | Read strobe, qualified by sel_i |
| wr_i | input | 1 | Write strobe, qualified by sel_i |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Register contents |
| irq_o | output | 1 | Registered error interrupt request |
| host_ctl_o | output | 1 | Host-facing control output |

## Verification
The bench builds the block with `SYNC_STAGES` = 2. That keeps the pin-to-flag delay at three edges, so the directed latency checks can sample the exact edge where a flag rises and the following edge where the interrupt follows. At that depth, two pins dropped in the same bench cycle arrive at the flags together. This brings the set-wins case between a bus-reset edge and a power-down edge within reach. Random sequences of reads, writes, pin pulses and software-reset pulses then cover armed and unarmed clears against a bench-side register model.

// File: rtl/hpe_pkg.sv
package hpe_pkg;

    localparam int REG_W    = 8;
    localparam int NUM_EVT  = 2;
    localparam int BIT_A20  = 7;
    localparam int BIT_RSTF = 6;
    localparam int BIT_PDF  = 5;
    localparam int BIT_CTL  = 0;
    localparam int RSVD_W   = BIT_PDF - BIT_CTL - 1;

    // Index of each pin event inside the event vectors
    typedef enum int {
        EVT_BUSRST = 0,
        EVT_PWRDN  = 1
    } evt_idx_e;

    typedef struct packed {
        logic              a20;
        logic              rst_flag;
        logic              pd_flag;
        logic [RSVD_W-1:0] rsvd;
        logic              ctl;
    } stat_reg_t;

    typedef struct packed {
        logic             rd_hit;
        logic             wr_hit;
        logic [REG_W-1:0] wdata;
    } reg_access_t;

    function automatic logic [REG_W-1:0] flatten_reg(input stat_reg_t r);
        stat_reg_t t;
        t      = r;
        t.rsvd = '0;
        return t;
    endfunction

    function automatic int flag_bit_pos(input int evt);
        return (evt == EVT_BUSRST) ? BIT_RSTF : BIT_PDF;
    endfunction

endpackage

// File: rtl/hpe_sync.sv
module hpe_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] shreg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q <= {STAGES{RST_VAL}};
        end else begin
            shreg_q <= {shreg_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = shreg_q[STAGES-1];

endmodule

// File: rtl/hpe_fall_det.sv
module hpe_fall_det (
    input  logic clk,
    input  logic rst,
    input  logic lvl_i,
    output logic fall_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b1;
        end else begin
            prev_q <= lvl_i;
        end
    end

    assign fall_o = prev_q & ~lvl_i;

    // R10: a level held low never reports two edges in a row
    assert_no_double_edge_R10: assert property (@(posedge clk) disable iff (rst)
        fall_o |=> !fall_o);

endmodule

// File: rtl/hpe_sticky_flag.sv
module hpe_sticky_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic hard_clr_i,
    input  logic rd_hit_i,
    input  logic wr_hit_i,
    input  logic wr_bit_i,
    output logic flag_o
);
    logic flag_q;
    logic arm_q;
    logic sw_clr;
    logic flag_d;
    logic arm_d;

    always_comb begin
        sw_clr = wr_hit_i & arm_q & ~wr_bit_i;
        flag_d = set_i | (flag_q & ~(sw_clr | hard_clr_i));
        arm_d  = flag_d & ~wr_hit_i & (arm_q | (rd_hit_i & flag_q));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            arm_q  <= 1'b0;
        end else begin
            flag_q <= flag_d;
            arm_q  <= arm_d;
        end
    end

    assign flag_o = flag_q;

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag_q);

    assert_rise_from_edge_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(set_i));

    assert_unarmed_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !arm_q && !hard_clr_i) |=> flag_q);

endmodule

// File: rtl/hpe_flag_reg.sv
module hpe_flag_reg
    import hpe_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_rst_n_i,
    input  logic             pwr_dn_n_i,
    input  logic             a20_pin_i,
    input  logic             sw_rst_i,
    input  logic             ctl_en_i,
    input  logic             sel_i,
    input  logic             rd_i,
    input  logic             wr_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] rdata_o,
    output logic             irq_o,
    output logic             host_ctl_o
);
    logic [NUM_EVT-1:0] pin_raw;
    logic [NUM_EVT-1:0] pin_sync;
    logic [NUM_EVT-1:0] pin_fall;
    logic [NUM_EVT-1:0] hard_clr;
    logic [NUM_EVT-1:0] flags;
    logic               a20_sync;
    logic               ctl_q;
    logic               irq_q;
    reg_access_t        acc;
    stat_reg_t          view;

    assign pin_raw[EVT_BUSRST] = bus_rst_n_i;
    assign pin_raw[EVT_PWRDN]  = pwr_dn_n_i;

    assign acc.rd_hit = sel_i & rd_i;
    assign acc.wr_hit = sel_i & wr_i;
    assign acc.wdata  = wdata_i;

    // Bus-reset flag has no extra clear; power-down flag is cleared by
    // a bus-reset edge or the software-reset level.
    assign hard_clr[EVT_BUSRST] = 1'b0;
    assign hard_clr[EVT_PWRDN]  = pin_fall[EVT_BUSRST] | sw_rst_i;

    for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
        hpe_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
            .clk (clk),
            .rst (rst),
            .d_i (pin_raw[e]),
            .q_o (pin_sync[e])
        );

        hpe_fall_det u_fall (
            .clk    (clk),
            .rst    (rst),
            .lvl_i  (pin_sync[e]),
            .fall_o (pin_fall[e])
        );

        hpe_sticky_flag u_flag (
            .clk        (clk),
            .rst        (rst),
            .set_i      (pin_fall[e]),
            .hard_clr_i (hard_clr[e]),
            .rd_hit_i   (acc.rd_hit),
            .wr_hit_i   (acc.wr_hit),
            .wr_bit_i   (acc.wdata[flag_bit_pos(e)]),
            .flag_o     (flags[e])
        );
    end

    hpe_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_a20_sync (
        .clk (clk),
        .rst (rst),
        .d_i (a20_pin_i),
        .q_o (a20_sync)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            if (acc.wr_hit) begin
                ctl_q <= acc.wdata[BIT_CTL];
            end
            irq_q <= |flags;
        end
    end

    always_comb begin
        view          = '0;
        view.a20      = a20_sync;
        view.rst_flag = flags[EVT_BUSRST];
        view.pd_flag  = flags[EVT_PWRDN];
        view.ctl      = ctl_q;
    end

    assign rdata_o    = flatten_reg(view);
    assign irq_o      = irq_q;
    assign host_ctl_o = ctl_q & ctl_en_i;

    assert_irq_follows_R8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_o == $past(rdata_o[BIT_RSTF] | rdata_o[BIT_PDF])));

    assert_pd_swclr_R6: assert property (@(posedge clk) disable iff (rst)
        (sw_rst_i && !pin_fall[EVT_PWRDN]) |=> !rdata_o[BIT_PDF]);

    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (rst)
        rdata_o[BIT_PDF-1:BIT_CTL+1] == '0);

endmodule

// File: tb/hpe_flag_reg_test.sv
module hpe_flag_reg_test;
    localparam int STG = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_rst_n = 1'b1;
    logic       pwr_dn_n = 1'b1;
    logic       a20_pin = 1'b0;
    logic       sw_rst = 1'b0;
    logic       ctl_en = 1'b0;
    logic       sel = 1'b0;
    logic       rd = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq;
    logic       host_ctl;

    int  checks = 0;
    int  fails = 0;
    bit  done = 1'b0;

    // bench register model
    bit m_a20, m_rf, m_pf, m_arm_r, m_arm_p, m_ctl;

    always #2.5 clk = ~clk;

    hpe_flag_reg #(.SYNC_STAGES(STG)) uut (
        .clk(clk), .rst(rst), .bus_rst_n_i(bus_rst_n), .pwr_dn_n_i(pwr_dn_n),
        .a20_pin_i(a20_pin), .sw_rst_i(sw_rst), .ctl_en_i(ctl_en),
        .sel_i(sel), .rd_i(rd), .wr_i(wr), .wdata_i(wdata),
        .rdata_o(rdata), .irq_o(irq), .host_ctl_o(host_ctl)
    );

    function automatic logic [7:0] exp_reg();
        return {m_a20, m_rf, m_pf, 4'b0000, m_ctl};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check({req, " reg"}, rdata, exp_reg());
        check({req, " irq R8"}, {7'd0, irq}, {7'd0, m_rf | m_pf});
        check({req, " host_ctl R9"}, {7'd0, host_ctl}, {7'd0, m_ctl & ctl_en});
    endtask

    task automatic settle();
        repeat (STG + 4) @(negedge clk);
    endtask

    task automatic do_read(input string req);
        sel = 1'b1; rd = 1'b1;
        @(negedge clk);
        check({req, " read value"}, rdata, exp_reg());
        sel = 1'b0; rd = 1'b0;
        if (m_rf) m_arm_r = 1'b1;
        if (m_pf) m_arm_p = 1'b1;
    endtask

    task automatic do_write(input logic [7:0] w);
        sel = 1'b1; wr = 1'b1; wdata = w;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
        if (m_arm_r && !w[6]) m_rf = 1'b0;
        if (m_arm_p && !w[5]) m_pf = 1'b0;
        m_arm_r = 1'b0; m_arm_p = 1'b0;
        m_ctl = w[0];
        settle();
    endtask

    task automatic pulse_pins(input bit r, input bit p, input int len);
        if (r) bus_rst_n = 1'b0;
        if (p) pwr_dn_n = 1'b0;
        repeat (len) @(negedge clk);
        bus_rst_n = 1'b1; pwr_dn_n = 1'b1;
        if (r && p) begin
            m_rf = 1'b1; m_pf = 1'b1;
        end else if (r) begin
            m_rf = 1'b1; m_pf = 1'b0; m_arm_p = 1'b0;
        end else if (p) begin
            m_pf = 1'b1;
        end
        settle();
    endtask

    task automatic pulse_swrst();
        sw_rst = 1'b1;
        @(negedge clk);
        sw_rst = 1'b0;
        m_pf = 1'b0; m_arm_p = 1'b0;
        settle();
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1 reset low bits", {1'b0, rdata[6:0]}, 8'h00);
        check("R1 reset irq", {7'd0, irq}, 8'h00);
        check("R1 reset host_ctl", {7'd0, host_ctl}, 8'h00);

        // R3 / R8 exact latency
        bus_rst_n = 1'b0;
        repeat (STG) @(negedge clk);
        check("R3 not yet set", {7'd0, rdata[6]}, 8'h00);
        @(negedge clk);
        check("R3 set after edge", {7'd0, rdata[6]}, 8'h01);
        check("R8 irq one cycle later", {7'd0, irq}, 8'h00);
        @(negedge clk);
        check("R8 irq asserted", {7'd0, irq}, 8'h01);
        bus_rst_n = 1'b1;
        m_rf = 1'b1;
        settle();
        check_all("R3");

        // R5: write 0 without a read is ignored
        do_write(8'h00);
        check_all("R5 unarmed write");
        check("R5 flag kept", {7'd0, rdata[6]}, 8'h01);
        do_read("R5");
        do_write(8'h00);
        check("R5 armed clear", {7'd0, rdata[6]}, 8'h00);
        do_write(8'h60);
        check("R5 write 1 no set", rdata[6:5], 2'b00);

        // R4 latency
        pwr_dn_n = 1'b0;
        repeat (STG + 1) @(negedge clk);
        check("R4 set after edge", {7'd0, rdata[5]}, 8'h01);
        pwr_dn_n = 1'b1; m_pf = 1'b1;
        settle();
        check_all("R4");

        // R6: bus reset edge clears power-down flag
        pulse_pins(1'b1, 1'b0, 3);
        check_all("R6 busrst clears pd");
        check("R6 pd zero", {7'd0, rdata[5]}, 8'h00);
        pulse_pins(1'b0, 1'b1, 2);
        pulse_swrst();
        check("R6 swrst clears pd", {7'd0, rdata[5]}, 8'h00);
        check_all("R6");

        // R7: both edges in the same cycle
        do_read("R7 prep"); do_write(8'h00);
        pulse_pins(1'b1, 1'b1, 2);
        check("R7 both set", rdata[6:5], 2'b11);
        check_all("R7");

        // R10: pin held low, cleared flag stays clear
        do_read("R10 prep"); do_write(8'h00);
        pwr_dn_n = 1'b0;
        repeat (STG + 2) @(negedge clk);
        m_pf = 1'b1;
        do_read("R10");
        do_write(8'h00);
        repeat (10) @(negedge clk);
        check("R10 no re-set on level", {7'd0, rdata[5]}, 8'h00);
        pwr_dn_n = 1'b1;
        settle();

        // R2 / R9 directed
        a20_pin = 1'b1;
        repeat (STG) @(negedge clk);
        m_a20 = 1'b1;
        check("R2 a20 level", {7'd0, rdata[7]}, 8'h01);
        do_write(8'h1F);
        check("R2 reserved ignored", {4'd0, rdata[4:1]}, 8'h00);
        ctl_en = 1'b1;
        @(negedge clk);
        check_all("R9 ctl enabled");
        ctl_en = 1'b0;
        @(negedge clk);
        check_all("R9 ctl disabled");

        // random mix
        for (int i = 0; i < 400; i++) begin
            int op;
            op = $urandom_range(0, 7);
            case (op)
                0: pulse_pins(1'b1, 1'b0, $urandom_range(1, 4));
                1: pulse_pins(1'b0, 1'b1, $urandom_range(1, 4));
                2: pulse_pins(1'b1, 1'b1, $urandom_range(1, 4));
                3: do_read("R5 rnd");
                4: do_write(8'($urandom));
                5: pulse_swrst();
                6: begin
                    a20_pin = $urandom_range(0, 1);
                    settle();
                    m_a20 = a20_pin;
                end
                default: begin
                    ctl_en = $urandom_range(0, 1);
                    @(negedge clk);
                end
            endcase
            check_all("R2 R5 R6 R9 rnd");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule